// File: doc/BRIEF.md
# Software-Driven Serial Pin Controller

This block lets host software run a serial link by hand through five pads: one clock pad, one data pad and three select pads. Every pad has its own direction bit and its own output value. A host port writes two registers. The direction register decides which pads the block drives. The drive register holds the output levels for the data and select pads, and it also chooses how the clock pad is driven.

The clock pad has two drive modes. In the first it copies a level that software stores. In the second, every write to the drive register fires one clock pulse of fixed length. The pulse can be active-high or active-low, and between pulses the pad sits at the inactive level. Software toggles data and select levels and gets a clock edge with each write, so it needs no separate clock toggling.

The read port always shows the live level of each pad after a two-flop synchronizer. A pad the block drives therefore reads back its own output, and a pad set as an input reads back what the outside world drives. Each pad is modelled as a separate output value, output enable and input level.

Top module: `serial_pin_ctrl`

## Requirements
- R1: After reset, every output enable is 0, automatic pulsing is off and the pulse polarity is active-high, so the clock output value rests at 0.
- R2: A write with `wr_sel`=0 loads the direction register from `wr_data`. Bit 4 enables the clock pad, bits 3, 2 and 1 enable select pads 3, 2 and 1, and bit 0 enables the data pad (1 = output). The enables change in the cycle after the write.
- R3: A write with `wr_sel`=1 loads the drive register. Bit 0 sets the data output and bits 6, 5 and 4 set select outputs 3, 2 and 1. They change in the cycle after the write and then hold until the next write.
- R4: When drive-register bit 1 (automatic) is 0, the clock output equals drive-register bit 2 from the cycle after the write onward.
- R5: When a drive-register write has bit 1 set, the clock output sits at the active level for exactly PULSE_LEN cycles, starting in the cycle after the write.
- R6: Drive-register bit 3 selects the polarity: 0 means the pulse is high and the resting level is 0, and 1 means the pulse is low and the resting level is 1.
- R7: An automatic write that arrives while a pulse is running reloads the length. The active level then continues without a gap and ends PULSE_LEN cycles after the last write.
- R8: `rd_data` bit 2 shows the clock pad, bit 0 the data pad, and bits 6, 5 and 4 select pads 3, 2 and 1, with no inversion. This holds whatever the pad directions are. A pad level appears there two cycles after it changes.
- R9: `rd_data` bits 7, 3 and 1 always read 0, even after 1s were written to those drive-register positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one write per high cycle |
| wr_sel | input | 1 | 0 selects the direction register, 1 the drive register |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Synchronized live pad levels |
| clk_pin_i | input | 1 | Clock pad input level |
| clk_pin_o | output | 1 | Clock pad output value |
| clk_pin_oe | output | 1 | Clock pad output enable |
| dat_pin_i | input | 1 | Data pad input level |
| dat_pin_o | output | 1 | Data pad output value |
| dat_pin_oe | output | 1 | Data pad output enable |
| sel_pin_i | input | 3 | Select pad input levels, index 2 = select 3, index 0 = select 1 |
| sel_pin_o | output | 3 | Select pad output values |
| sel_pin_oe | output | 3 | Select pad output enables |

## Verification
Most wrong internal state in this block shows at the pads within one cycle of a write. A miscounted pulse counter makes the clock pulse one cycle too long or too short, or leaves a gap when a pulse is restarted. A misrouted direction or drive bit changes an enable or a level in the cycle after the write. Errors in the synchronizer path surface later: they appear on `rd_data` two cycles after the pad changes, or three cycles after a write for pads the block drives. That includes a missing stage, an inverted bit or an input taken from the wrong pad.

// File: rtl/spc_pkg.sv
package spc_pkg;

  // direction register image, bit 4 down to bit 0
  typedef struct packed {
    logic       clk_oe;
    logic [2:0] sel_oe;
    logic       dat_oe;
  } spc_dir_t;

  // drive register image, bit 6 down to bit 0
  typedef struct packed {
    logic [2:0] sel_out;
    logic       pol_low;
    logic       clk_lvl;
    logic       auto_en;
    logic       dat_out;
  } spc_drv_t;

  localparam int DIR_W = $bits(spc_dir_t);
  localparam int DRV_W = $bits(spc_drv_t);

  // level on the clock output for the current mode and pulse state
  function automatic logic clk_drive(input logic auto_en, input logic pol_low,
                                     input logic active, input logic lvl);
    logic pulse_lvl;
    pulse_lvl = active ? ~pol_low : pol_low;
    return auto_en ? pulse_lvl : lvl;
  endfunction

  // readback word built from synchronized pad levels
  function automatic logic [7:0] pack_levels(input logic clk_l, input logic dat_l,
                                             input logic [2:0] sel_l);
    return {1'b0, sel_l, 1'b0, clk_l, 1'b0, dat_l};
  endfunction

endpackage

// File: rtl/spc_sync.sv
module spc_sync #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_in[g];
        stab_q <= meta_q;
      end
    end
    assign sync_out[g] = stab_q;
  end
endmodule

// File: rtl/spc_regs.sv
module spc_regs
  import spc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output spc_dir_t   dir_q,
  output spc_drv_t   drv_q,
  output spc_drv_t   drv_d,
  output logic       drv_wr,
  output logic       pulse_start
);
  spc_dir_t dir_d;
  logic     dir_wr;

  assign dir_wr      = wr_en && !wr_sel;
  assign drv_wr      = wr_en && wr_sel;
  assign dir_d       = dir_wr ? spc_dir_t'(wr_data[DIR_W-1:0]) : dir_q;
  assign drv_d       = drv_wr ? spc_drv_t'(wr_data[DRV_W-1:0]) : drv_q;
  assign pulse_start = drv_wr && wr_data[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      drv_q <= '0;
    end else begin
      dir_q <= dir_d;
      drv_q <= drv_d;
    end
  end
endmodule

// File: rtl/spc_pulse.sv
module spc_pulse #(
  parameter int PULSE_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active_d,
  output logic active_q,
  output logic restart
);
  localparam int CW = $clog2(PULSE_LEN + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (start)
      cnt_d = CW'(PULSE_LEN);
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
    else
      cnt_d = cnt_q;
  end

  assign active_d = (cnt_d != '0);
  assign active_q = (cnt_q != '0);
  assign restart  = start && active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/serial_pin_ctrl.sv
module serial_pin_ctrl
  import spc_pkg::*;
#(
  parameter int PULSE_LEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       clk_pin_i,
  output logic       clk_pin_o,
  output logic       clk_pin_oe,
  input  logic       dat_pin_i,
  output logic       dat_pin_o,
  output logic       dat_pin_oe,
  input  logic [2:0] sel_pin_i,
  output logic [2:0] sel_pin_o,
  output logic [2:0] sel_pin_oe
);
  localparam int NPAD = 5;

  spc_dir_t dir_q;
  spc_drv_t drv_q, drv_d;
  logic     drv_wr, pulse_start, pulse_active_d, pulse_active, pulse_restart;
  logic     clk_o_q;
  logic [NPAD-1:0] pad_raw, pad_sync;

  spc_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .dir_q      (dir_q),
    .drv_q      (drv_q),
    .drv_d      (drv_d),
    .drv_wr     (drv_wr),
    .pulse_start(pulse_start)
  );

  spc_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (pulse_start),
    .active_d(pulse_active_d),
    .active_q(pulse_active),
    .restart (pulse_restart)
  );

  // clock output register follows the next-state of mode and counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_o_q <= 1'b0;
    else        clk_o_q <= clk_drive(drv_d.auto_en, drv_d.pol_low, pulse_active_d, drv_d.clk_lvl);
  end

  assign pad_raw = {clk_pin_i, sel_pin_i, dat_pin_i};

  spc_sync #(.WIDTH(NPAD)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(pad_raw),
    .sync_out(pad_sync)
  );

  assign rd_data    = pack_levels(pad_sync[4], pad_sync[0], pad_sync[3:1]);
  assign clk_pin_o  = clk_o_q;
  assign clk_pin_oe = dir_q.clk_oe;
  assign dat_pin_o  = drv_q.dat_out;
  assign dat_pin_oe = dir_q.dat_oe;
  assign sel_pin_o  = drv_q.sel_out;
  assign sel_pin_oe = dir_q.sel_oe;
endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
  parameter int PULSE_LEN = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_sel,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       dat_pin_i,
  input logic       clk_pin_o,
  input logic       clk_pin_oe,
  input logic       dat_pin_oe,
  input logic [2:0] sel_pin_oe,
  input logic       pulse_start,
  input logic       pulse_active,
  input logic       auto_en,
  input logic       pol_low
);
  localparam int RW = $clog2(PULSE_LEN + 2) + 1;

  logic [RW-1:0] run_q;
  logic [1:0]    age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      age_q <= '0;
    end else begin
      if (pulse_start)       run_q <= RW'(1);
      else if (pulse_active) run_q <= run_q + 1'b1;
      else                   run_q <= '0;
      if (age_q != 2'd3) age_q <= age_q + 1'b1;
    end
  end

  // R1: enables come out of reset cleared
  p_reset_dir_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ({clk_pin_oe, sel_pin_oe, dat_pin_oe} == 5'b0));

  // R2: direction write lands one cycle later
  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> ({clk_pin_oe, sel_pin_oe, dat_pin_oe} == $past(wr_data[4:0])));

  // R4: direct mode copies the stored level
  p_direct_lvl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && !wr_data[1]) |=> (clk_pin_o == $past(wr_data[2])));

  // R5: an automatic write starts the active level next cycle
  p_pulse_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_start |=> (clk_pin_o == !pol_low));

  // R6: outside a pulse the clock output rests at the inactive level
  p_rest_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !pulse_active) |-> (clk_pin_o == pol_low));

  // R7: no active run exceeds the length since its last start
  p_run_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_active |-> (run_q <= RW'(PULSE_LEN)));

  // R8: data pad level reaches the read port after two cycles
  p_rd_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) |-> (rd_data[0] == $past(dat_pin_i, 2)));
endmodule

bind serial_pin_ctrl spc_checker #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .wr_data     (wr_data),
  .rd_data     (rd_data),
  .dat_pin_i   (dat_pin_i),
  .clk_pin_o   (clk_pin_o),
  .clk_pin_oe  (clk_pin_oe),
  .dat_pin_oe  (dat_pin_oe),
  .sel_pin_oe  (sel_pin_oe),
  .pulse_start (pulse_start),
  .pulse_active(pulse_active),
  .auto_en     (drv_q.auto_en),
  .pol_low     (drv_q.pol_low)
);

// File: tb/sim_serial_pin_ctrl.sv
`timescale 1ns/1ps
module sim_serial_pin_ctrl;
  localparam int PL = 2;

  typedef struct {
    int         due;
    int         kind;
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       clk_pin_i, clk_pin_o, clk_pin_oe;
  logic       dat_pin_i, dat_pin_o, dat_pin_oe;
  logic [2:0] sel_pin_i, sel_pin_o, sel_pin_oe;
  logic       ext_clk = 1'b1, ext_dat = 1'b0;
  logic [2:0] ext_sel = 3'b101;

  int    cyc = 0;
  int    checks = 0, failures = 0;
  bit    done = 0;
  item_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // pad model: driven pads read back their own value
  assign clk_pin_i = clk_pin_oe ? clk_pin_o : ext_clk;
  assign dat_pin_i = dat_pin_oe ? dat_pin_o : ext_dat;
  for (genvar g = 0; g < 3; g++) begin : g_pad
    assign sel_pin_i[g] = sel_pin_oe[g] ? sel_pin_o[g] : ext_sel[g];
  end

  serial_pin_ctrl #(.PULSE_LEN(PL)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_data(rd_data), .clk_pin_i(clk_pin_i), .clk_pin_o(clk_pin_o), .clk_pin_oe(clk_pin_oe),
    .dat_pin_i(dat_pin_i), .dat_pin_o(dat_pin_o), .dat_pin_oe(dat_pin_oe),
    .sel_pin_i(sel_pin_i), .sel_pin_o(sel_pin_o), .sel_pin_oe(sel_pin_oe)
  );

  function automatic logic [7:0] observe(int kind);
    case (kind)
      0:       return {7'b0, clk_pin_o};
      1:       return {3'b0, clk_pin_oe, sel_pin_oe, dat_pin_oe};
      2:       return rd_data;
      default: return {4'b0, sel_pin_o, dat_pin_o};
    endcase
  endfunction

  task automatic expect_at(int due, int kind, logic [7:0] val, string tag);
    item_t it;
    it.due = due; it.kind = kind; it.exp = val; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compares every item whose cycle has come
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        logic [7:0] got;
        got = observe(sb[i].kind);
        checks++;
        if (got !== sb[i].exp) begin
          failures++;
          $display("FAIL %s cycle %0d kind %0d actual=%h expected=%h",
                   sb[i].tag, cyc, sb[i].kind, got, sb[i].exp);
        end
        sb.delete(i);
      end
    end
  end

  task automatic wr_start(logic sel, logic [7:0] d, output int n);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    n = cyc;
  endtask

  task automatic wr_end();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    int n, m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state; R8 inputs visible on read port
    expect_at(cyc + 1, 1, 8'h00, "R1 enables");
    expect_at(cyc + 1, 0, 8'h00, "R1 clock rest");
    expect_at(cyc + 3, 2, 8'h54, "R8 reset readback");
    idle(4);

    // R2 all outputs; R3 drive levels; R4 direct clock
    wr_start(1'b0, 8'h1F, n);
    expect_at(n + 1, 1, 8'h1F, "R2 all out");
    wr_end();
    wr_start(1'b1, 8'h65, n);
    expect_at(n + 1, 0, 8'h01, "R4 direct high");
    expect_at(n + 1, 3, 8'h0D, "R3 drive levels");
    expect_at(n + 3, 2, 8'h65, "R8 driven readback");
    wr_end();
    expect_at(n + 4, 3, 8'h0D, "R3 levels hold");
    idle(4);

    // R2 mixed directions; R8 external levels through inputs
    ext_sel = 3'b010; ext_clk = 1'b0; ext_dat = 1'b0;
    wr_start(1'b0, 8'h0A, n);
    expect_at(n + 1, 1, 8'h0A, "R2 mixed dirs");
    expect_at(n + 3, 2, 8'h60, "R8 mixed readback");
    wr_end();
    idle(4);

    // R5 active-high auto pulse, R9 unused read bits zero
    wr_start(1'b0, 8'h1F, n);
    wr_end();
    wr_start(1'b1, 8'h03, n);
    expect_at(n + 1, 0, 8'h01, "R5 pulse first");
    expect_at(n + 2, 0, 8'h01, "R5 pulse last");
    expect_at(n + 3, 0, 8'h00, "R5 pulse end");
    expect_at(n + 3, 2, 8'h05, "R9 pulse readback");
    expect_at(n + 5, 2, 8'h01, "R8 clock back low");
    wr_end();
    idle(5);

    // R6 active-low pulse
    wr_start(1'b1, 8'h0A, n);
    expect_at(n + 1, 0, 8'h00, "R6 low pulse");
    expect_at(n + 2, 0, 8'h00, "R6 low pulse last");
    expect_at(n + 3, 0, 8'h01, "R6 rest high");
    expect_at(n + 6, 0, 8'h01, "R6 rest holds");
    wr_end();
    idle(6);

    // R7 back-to-back writes restart without a gap
    wr_start(1'b1, 8'h02, n);
    @(negedge clk);
    m = cyc;
    expect_at(m + 1, 0, 8'h01, "R7 no gap");
    expect_at(m + PL, 0, 8'h01, "R7 extended");
    expect_at(m + PL + 1, 0, 8'h00, "R7 end after last");
    wr_end();
    idle(5);

    // R4 back to direct mode, level held
    wr_start(1'b1, 8'h04, n);
    expect_at(n + 1, 0, 8'h01, "R4 direct again");
    expect_at(n + 4, 0, 8'h01, "R4 direct holds");
    wr_end();
    idle(5);

    // R8 clock pad as input while pulsing: read port follows outside level
    ext_clk = 1'b1;
    wr_start(1'b0, 8'h00, n);
    expect_at(n + 1, 1, 8'h00, "R2 all in");
    wr_end();
    wr_start(1'b1, 8'h0A, n);
    expect_at(n + 1, 2, 8'h24, "R8 input clock pad");
    expect_at(n + 2, 2, 8'h24, "R8 input clock pad hold");
    wr_end();
    idle(6);

    if (sb.size() != 0) begin
      checks++; failures++;
      $display("FAIL scoreboard left actual=%0d expected=0", sb.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule